// File: doc/BRIEF.md
# Trace Address Compression Packetizer

This block turns the instruction stream of a processor into a compact trace. Every cycle it reports a two-bit pipeline status on its own status pins. For ordinary execution and for direct branches it sends no address, because the host-side decoder holds the program image and can rebuild the flow from the status alone. Only an indirect branch, whose target cannot be inferred, sends address bytes. Even then, only the low-order 7-bit groups that changed since the last address sent leave the chip.

Address bytes enter a byte FIFO in bursts of one to five. They are drained at a steady rate onto a narrow trace data port whose width is a parameter: 4, 8 or 16 bits. If a burst does not fit in the free space, it is dropped whole and an overflow pulse is raised. The next indirect target is then sent in full, so the decoder can resynchronise.

Top module: `trc_packetizer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `trc_stat` is 00, `trc_ovf` is 0 and every bit of `trc_valid` is 0.
- R2: The status for the instruction sampled at a clock edge appears on `trc_stat` right after that edge. The codes are 00 when `exec_valid` is low, 11 for an indirect branch (whatever `br_taken` is), 10 for a taken direct branch and 01 for any other executed instruction.
- R3: Byte i of an emitted address carries address bits [7i+6:7i] in bits 6..0. The fifth byte carries bits 31..28 in bits 3..0, with bits 6..4 zero. Bit 7 is 1 on every byte except the last byte of the address, where it is 0. Bytes go out lowest group first.
- R4: The number of bytes is one more than the index of the highest 7-bit group in which the new target differs from the reference address. It is at least 1, so an unchanged target still sends one byte.
- R5: The reference address is reset to zero. It takes a target's value only when that target's bytes are actually written into the FIFO.
- R6: With an 8-bit port, one byte leaves per cycle while the FIFO holds data. A byte written at one edge can appear on `trc_data` at the following edge. Bytes leave in the order they were written, with no loss or duplication.
- R7: A burst is written only if its byte count does not exceed DEPTH minus the occupancy before the edge; bytes drained at that same edge are not counted as free. Otherwise nothing is written, and `trc_ovf` pulses together with status 11.
- R8: After an overflow, the next indirect target that is written is sent as all five bytes, whatever the reference address holds.
- R9: With a 16-bit port, bits 7..0 carry the older byte and bits 15..8 the next one. `trc_valid[0]` is high when at least one byte is held and `trc_valid[1]` when at least two are held. Up to two bytes leave per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_valid | input | 1 | An instruction completed this cycle |
| br_taken | input | 1 | The completed instruction was a taken direct branch |
| br_indirect | input | 1 | The completed instruction was an indirect branch |
| pc | input | 32 | Address of the instruction, or the branch target for indirect branches |
| trc_stat | output | 2 | Pipeline status code, one per cycle |
| trc_ovf | output | 1 | Pulse: the address burst of this status was dropped |
| trc_data | output | OUT_W | Trace data packet |
| trc_valid | output | 1 or 2 | Per-lane valid (two lanes only when OUT_W is 16) |

## Verification
Every cycle, the assertions check the following:
- An idle input gives status 00.
- An overflow pulse always comes with the indirect status.
- Bytes are pushed only for indirect branches.
- A push never exceeds the free entries.
- The reference address holds whenever nothing is pushed.
- The first push after an overflow is five bytes long.

Only the bench's scenarios can show the rest. These are the exact byte values and counts for each address change, the drain order and rate, and the cycle at which overflow strikes. To cover them, the bench runs two port widths side by side against a byte-level model. It uses directed cases for unchanged, top-group and all-group changes and a deliberate overflow burst, followed by a long random stream.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_SEQ      = 2'b01,
        ST_DIRECT   = 2'b10,
        ST_INDIRECT = 2'b11
    } trc_stat_e;

    localparam int ADDR_W    = 32;
    localparam int GRP_W     = 7;
    localparam int MAX_BYTES = (ADDR_W + GRP_W - 1) / GRP_W;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

endpackage

// File: rtl/trc_addr_enc.sv
module trc_addr_enc
    import trc_pkg::*;
(
    input  logic [ADDR_W-1:0]               tgt,
    input  logic [ADDR_W-1:0]               ref_addr,
    input  logic                            force_full,
    output logic [CNT_W-1:0]                nbytes,
    output logic [MAX_BYTES-1:0][7:0]       bytes
);

    logic [ADDR_W-1:0] diff;
    logic [CNT_W-1:0]  n_raw;

    always_comb begin
        diff  = tgt ^ ref_addr;
        n_raw = CNT_W'(1);
        for (int g = 1; g < MAX_BYTES; g++) begin
            if ((diff >> (g * GRP_W)) != '0) n_raw = CNT_W'(g + 1);
        end
        nbytes = force_full ? CNT_W'(MAX_BYTES) : n_raw;
    end

    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
        logic [GRP_W-1:0] grp;
        assign grp      = GRP_W'(tgt >> (i * GRP_W));
        assign bytes[i] = {(CNT_W'(i) + CNT_W'(1)) < nbytes, grp};
    end

endmodule

// File: rtl/trc_fifo.sv
module trc_fifo
    import trc_pkg::*;
#(
    parameter int DEPTH = 9,
    parameter int OUT_W = 8,
    localparam int LANES = (OUT_W == 16) ? 2 : 1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           push_n,
    input  logic [MAX_BYTES-1:0][7:0]  push_data,
    output logic [LVL_W-1:0]           level,
    output logic [OUT_W-1:0]           out_data,
    output logic [LANES-1:0]           out_valid
);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [LVL_W-1:0] lvl;
        logic [OUT_W-1:0] odata;
        logic [LANES-1:0] ovalid;
        logic             phase;
    } fifo_st_t;

    fifo_st_t   s_q, s_d;
    logic [7:0] mem [DEPTH];

    logic [1:0]       pop_n;
    logic [OUT_W-1:0] odata_nx;
    logic [LANES-1:0] ovalid_nx;
    logic             phase_nx;

    function automatic logic [PTR_W-1:0] wrap(input int unsigned p);
        return PTR_W'(p % DEPTH);
    endfunction

    logic [PTR_W-1:0] rd1;
    assign rd1 = wrap(int'(s_q.rd) + 1);

    if (OUT_W == 16) begin : g_w16
        always_comb begin
            pop_n     = (s_q.lvl >= LVL_W'(2)) ? 2'd2 : (s_q.lvl != '0) ? 2'd1 : 2'd0;
            odata_nx  = {mem[rd1], mem[s_q.rd]};
            ovalid_nx = {s_q.lvl >= LVL_W'(2), s_q.lvl != '0};
            phase_nx  = 1'b0;
        end
    end else if (OUT_W == 8) begin : g_w8
        always_comb begin
            pop_n     = (s_q.lvl != '0) ? 2'd1 : 2'd0;
            odata_nx  = mem[s_q.rd];
            ovalid_nx = s_q.lvl != '0;
            phase_nx  = 1'b0;
        end
    end else begin : g_w4
        always_comb begin
            pop_n     = (s_q.lvl != '0 && s_q.phase) ? 2'd1 : 2'd0;
            odata_nx  = s_q.phase ? mem[s_q.rd][7:4] : mem[s_q.rd][3:0];
            ovalid_nx = s_q.lvl != '0;
            phase_nx  = (s_q.lvl != '0) ? ~s_q.phase : s_q.phase;
        end
    end

    always_comb begin
        s_d        = s_q;
        s_d.rd     = wrap(int'(s_q.rd) + int'(pop_n));
        s_d.wr     = wrap(int'(s_q.wr) + int'(push_n));
        s_d.lvl    = s_q.lvl - LVL_W'(pop_n) + LVL_W'(push_n);
        s_d.odata  = odata_nx;
        s_d.ovalid = ovalid_nx;
        s_d.phase  = phase_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (CNT_W'(i) < push_n) mem[wrap(int'(s_q.wr) + i)] <= push_data[i];
        end
    end

    assign level     = s_q.lvl;
    assign out_data  = s_q.odata;
    assign out_valid = s_q.ovalid;

    assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lvl <= LVL_W'(DEPTH));

    assert_push_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(push_n) <= DEPTH - int'(s_q.lvl));

endmodule

// File: rtl/trc_packetizer.sv
module trc_packetizer
    import trc_pkg::*;
#(
    parameter int DEPTH = 9,
    parameter int OUT_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               exec_valid,
    input  logic                               br_taken,
    input  logic                               br_indirect,
    input  logic [31:0]                        pc,
    output logic [1:0]                         trc_stat,
    output logic                               trc_ovf,
    output logic [OUT_W-1:0]                   trc_data,
    output logic [((OUT_W == 16) ? 2 : 1)-1:0] trc_valid
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        trc_stat_e         stat;
        logic              ovf;
        logic [ADDR_W-1:0] last;
        logic              resync;
    } top_st_t;

    top_st_t s_q, s_d;

    logic [CNT_W-1:0]          need;
    logic [MAX_BYTES-1:0][7:0] enc_bytes;
    logic [LVL_W-1:0]          level;
    logic [CNT_W-1:0]          push_n;
    logic                      is_ind, fits;

    trc_addr_enc u_enc (
        .tgt       (pc),
        .ref_addr  (s_q.last),
        .force_full(s_q.resync),
        .nbytes    (need),
        .bytes     (enc_bytes)
    );

    trc_fifo #(.DEPTH(DEPTH), .OUT_W(OUT_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_n   (push_n),
        .push_data(enc_bytes),
        .level    (level),
        .out_data (trc_data),
        .out_valid(trc_valid)
    );

    always_comb begin
        is_ind = exec_valid && br_indirect;
        fits   = int'(need) <= DEPTH - int'(level);
        push_n = (is_ind && fits) ? need : '0;

        s_d     = s_q;
        s_d.ovf = is_ind && !fits;
        if (!exec_valid)     s_d.stat = ST_IDLE;
        else if (br_indirect) s_d.stat = ST_INDIRECT;
        else if (br_taken)   s_d.stat = ST_DIRECT;
        else                 s_d.stat = ST_SEQ;

        if (is_ind && fits) begin
            s_d.last   = pc;
            s_d.resync = 1'b0;
        end else if (is_ind) begin
            s_d.resync = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{stat: ST_IDLE, ovf: 1'b0, last: '0, resync: 1'b0};
        else        s_q <= s_d;
    end

    assign trc_stat = s_q.stat;
    assign trc_ovf  = s_q.ovf;

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |=> trc_stat == ST_IDLE);

    assert_ovf_stat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trc_ovf |-> trc_stat == ST_INDIRECT);

    assert_push_indirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_n != '0 |-> exec_valid && br_indirect);

    assert_ref_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push_n == '0 |=> $stable(s_q.last));

    assert_resync_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.resync && push_n != '0) |-> push_n == CNT_W'(MAX_BYTES));

endmodule

// File: tb/tb_trc_packetizer.sv
`timescale 1ns/1ps
module tb_trc_packetizer;

    localparam int DEPTH = 9;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, exec_valid, br_taken, br_indirect;
    logic [31:0] pc;
    logic [1:0]  stat8, stat16;
    logic        ovf8, ovf16;
    logic [7:0]  data8;
    logic [15:0] data16;
    logic [0:0]  val8;
    logic [1:0]  val16;

    trc_packetizer #(.DEPTH(DEPTH), .OUT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .br_taken(br_taken),
        .br_indirect(br_indirect), .pc(pc), .trc_stat(stat8), .trc_ovf(ovf8),
        .trc_data(data8), .trc_valid(val8));

    trc_packetizer #(.DEPTH(DEPTH), .OUT_W(16)) dut16 (
        .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .br_taken(br_taken),
        .br_indirect(br_indirect), .pc(pc), .trc_stat(stat16), .trc_ovf(ovf16),
        .trc_data(data16), .trc_valid(val16));

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string tag = "R6";

    logic [7:0]  mq0[$], mq1[$];
    logic [31:0] mlast[2];
    bit          mres[2];

    function automatic int need_bytes(logic [31:0] a, logic [31:0] r, bit full);
        logic [31:0] d = a ^ r;
        int n = 1;
        if (full) return 5;
        for (int g = 1; g < 5; g++) if ((d >> (7 * g)) != 0) n = g + 1;
        return n;
    endfunction

    function automatic logic [7:0] enc_byte(logic [31:0] a, int i, int n);
        logic [6:0] grp = 7'((a >> (7 * i)) & 32'h7f);
        return {(i < n - 1) ? 1'b1 : 1'b0, grp};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_inst(int k);
        logic [7:0] q[$];
        int lanes = (k == 1) ? 2 : 1;
        int cnt, need;
        logic [1:0] est, ast, aval;
        logic eov, aov;
        logic [15:0] adat;
        bit e0, e1;
        q = (k == 1) ? mq1 : mq0;
        ast  = (k == 1) ? stat16 : stat8;
        aov  = (k == 1) ? ovf16 : ovf8;
        adat = (k == 1) ? data16 : {8'h00, data8};
        aval = (k == 1) ? val16 : {1'b0, val8};
        cnt = q.size();
        e0 = cnt > 0;
        e1 = (lanes == 2) && cnt > 1;
        check(k == 1 ? "R9" : "R6", "valid", 32'(aval), {30'd0, e1, e0});
        if (e0) check(k == 1 ? "R9" : tag, "lane0 byte", 32'(adat[7:0]), 32'(q[0]));
        if (e1) check("R9", "lane1 byte", 32'(adat[15:8]), 32'(q[1]));
        if (e0) void'(q.pop_front());
        if (e1) void'(q.pop_front());
        est = !exec_valid ? 2'b00 : br_indirect ? 2'b11 : br_taken ? 2'b10 : 2'b01;
        eov = 1'b0;
        if (exec_valid && br_indirect) begin
            need = need_bytes(pc, mlast[k], mres[k]);
            if (need <= DEPTH - cnt) begin
                for (int i = 0; i < need; i++) q.push_back(enc_byte(pc, i, need));
                mlast[k] = pc;
                mres[k]  = 0;
            end else begin
                eov = 1'b1;
                mres[k] = 1;
            end
        end
        check("R2", "status", 32'(ast), 32'(est));
        check("R7", "overflow", 32'(aov), 32'(eov));
        if (k == 1) mq1 = q; else mq0 = q;
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        model_inst(0);
        model_inst(1);
    endtask

    task automatic drive(bit e, bit t, bit ind, logic [31:0] a);
        exec_valid = e; br_taken = t; br_indirect = ind; pc = a;
        cycle();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; exec_valid = 0; br_taken = 0; br_indirect = 0; pc = '0;
        mlast[0] = '0; mlast[1] = '0; mres[0] = 0; mres[1] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state on both widths
        check("R1", "stat in reset", 32'(stat8), 0);
        check("R1", "ovf in reset", 32'(ovf8), 0);
        check("R1", "valid in reset", 32'(val8), 0);
        check("R1", "valid16 in reset", 32'(val16), 0);
        rst_n = 1;
        cycle();
        check("R1", "stat after reset", 32'(stat8), 0);

        // R2: each status code
        drive(1, 0, 0, 32'h100);
        drive(1, 1, 0, 32'h200);
        drive(0, 1, 1, 32'h300);
        drive(1, 1, 1, 32'h0);       // R4: unchanged target -> one byte
        drive(0, 0, 0, 0);
        tag = "R3";
        drive(1, 0, 1, 32'h8000_0000); // top group differs -> five bytes
        drive(1, 0, 1, 32'h8000_0005); // R4: low group only
        repeat (8) drive(0, 0, 0, 0);
        tag = "R7";
        for (int i = 0; i < 4; i++)
            drive(1, 0, 1, (i % 2 == 0) ? 32'h1234_5678 : 32'hEDCB_A987);
        repeat (10) drive(1, 0, 0, 32'h400);
        tag = "R8";
        drive(1, 0, 1, 32'hEDCB_A988);  // R8: resync forces five bytes
        drive(1, 0, 1, 32'hEDCB_A989);  // R5: reference advanced, one byte
        repeat (8) drive(0, 0, 0, 0);

        tag = "R6";
        for (int c = 0; c < 4000; c++) begin
            logic [31:0] a;
            bit e, ind, t;
            e   = ($urandom % 10) < 8;
            ind = e && ($urandom % 7 == 0);
            t   = ($urandom % 3) == 0;
            case ($urandom % 4)
                0: a = pc + 32'd4;
                1: a = pc ^ ($urandom & 32'h7f);
                2: a = pc ^ ($urandom & 32'h3fff);
                default: a = $urandom;
            endcase
            drive(e, t, ind, a);
        end
        repeat (20) drive(0, 0, 0, 0);
        check("R6", "queue drained", 32'(mq0.size()), 0);
        check("R9", "queue16 drained", 32'(mq1.size()), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule